// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the logic model of a 64-word by 16-bit serial EEPROM. A host drives a select line, a serial clock and a data-in line, and listens on one data-out line that can go high-impedance. All three inputs are synchronised into a faster system clock, and the rising edges of the serial clock are detected in that clock domain. Each command begins at a start bit, so the host may send filler zeros first. The start bit is followed by a 2-bit opcode and a 6-bit word address. Four operations are decoded: read, write, write-enable and write-disable.

A read returns the addressed word after one dummy zero. If the host keeps clocking with select held high, the words that follow come out in order with no gap. A write loads 16 data bits and replaces the whole stored word. The internal write time lasts a parameter number of system clocks. While that time runs, the output pin reports busy or ready. Storage is a register array. It resets to the erased value, and the block starts in the write-disabled state.

Top module: `serial_eeprom_slave`

## Requirements
- R1: Whenever the synchronised select is low, `do_oe_o` is 0. It is also 0 after reset.
- R2: After reset, every word reads as 0xFFFF and writes are disabled.
- R3: After select rises, the first 1 sampled on DI at a serial-clock rising edge is the start bit. Any number of 0s sampled before it are ignored.
- R4: A command is the start bit, then an opcode of 2 bits sent MSB first, then an address of 6 bits sent MSB first. Opcode 10 is read and 01 is write. Opcode 00 enables writes when address bits [5:4] are 11, and disables writes when they are 00.
- R5: For a read, DO is driven with a 0 at the clock edge that captures the last address bit. At each of the next 16 rising edges, DO carries the data bits, most significant first.
- R6: If clocking continues during a read, the next word follows directly after bit 0. The address after 63 is 0.
- R7: An accepted write takes 16 data bits, MSB first, and replaces the addressed word completely.
- R8: A write is ignored if writes are disabled, or if the previous write time is still running.
- R9: Once a write command completes, busy lasts WRITE_CYCLES system clocks. While select is high and no start bit has yet been seen, DO is driven with 0 during busy and 1 when ready. The start bit ends this status display.
- R10: When select goes low, any partly received command is discarded. A new command needs a fresh rise of select.
- R11: The disable command blocks later writes. Reads work whether writes are enabled or disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial command, address and data input |
| do_o | output | 1 | Serial data or ready/busy status |
| do_oe_o | output | 1 | Output enable for do_o (0 means high-impedance) |

## Verification
The hardest case to reach is a write that arrives while the previous write is still busy. The second write must be a complete 25-bit command issued in a new select window before the write timer expires. The bench therefore sets WRITE_CYCLES longer than one full command and sends the second write straight after the first. It then checks the busy level on DO, and finally reads the word back to confirm it still holds the erased value. The wrap from address 63 to 0 is reached by writing both end words and reading 32 bits continuously from address 63.

// File: rtl/sep_pkg.sv
package sep_pkg;
   typedef enum logic [2:0] {
      ST_HUNT,
      ST_OPC,
      ST_ADR,
      ST_RD,
      ST_WDAT,
      ST_DONE
   } sep_state_e;

   localparam logic [1:0] OP_SPECIAL = 2'b00;
   localparam logic [1:0] OP_WRITE   = 2'b01;
   localparam logic [1:0] OP_READ    = 2'b10;

   localparam logic [1:0] SUB_ENABLE  = 2'b11;
   localparam logic [1:0] SUB_DISABLE = 2'b00;
endpackage

// File: rtl/sep_sync.sv
module sep_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] pipe;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= d;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/sep_array.sv
module sep_array #(
   parameter int              ADDR_W       = 6,
   parameter int              DATA_W       = 16,
   parameter int              WRITE_CYCLES = 1000,
   parameter logic [DATA_W-1:0] ERASED     = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wen_set,
   input  logic              wen_clr,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              wen
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int TW    = $clog2(WRITE_CYCLES + 1);

   logic [DATA_W-1:0] cells [DEPTH];
   logic [TW-1:0]     timer;
   logic              accept;

   assign busy    = (timer != '0);
   assign accept  = wr_req && wen && !busy;
   assign rd_data = cells[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
      end else if (accept) begin
         cells[wr_addr] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       timer <= '0;
      else if (accept)  timer <= TW'(WRITE_CYCLES);
      else if (busy)    timer <= timer - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wen <= 1'b0;
      else if (wen_set) wen <= 1'b1;
      else if (wen_clr) wen <= 1'b0;
   end
endmodule

// File: rtl/sep_ctrl.sv
module sep_ctrl
   import sep_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sk_rise,
   input  logic              di_s,
   input  logic              busy,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_req,
   output logic [DATA_W-1:0] wr_data,
   output logic              wen_set,
   output logic              wen_clr,
   output logic              do_bit,
   output logic              do_oe,
   output logic              rd_active
);
   localparam int CW = $clog2(DATA_W);
   localparam logic [CW-1:0] LAST_D = CW'(DATA_W - 1);
   localparam logic [CW-1:0] LAST_A = CW'(ADDR_W - 1);

   sep_state_e        state;
   logic [1:0]        opc;
   logic [CW-1:0]     cnt;
   logic [DATA_W-1:0] shreg;
   logic              rd_bit;
   logic              armed;
   logic [ADDR_W-1:0] nxt_addr;
   logic [DATA_W-1:0] nxt_data;

   assign nxt_addr = {addr[ADDR_W-2:0], di_s};
   assign nxt_data = {shreg[DATA_W-2:0], di_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_HUNT;
         opc     <= '0;
         cnt     <= '0;
         addr    <= '0;
         shreg   <= '0;
         rd_bit  <= 1'b0;
         armed   <= 1'b0;
         wr_req  <= 1'b0;
         wr_data <= '0;
         wen_set <= 1'b0;
         wen_clr <= 1'b0;
      end else begin
         wr_req  <= 1'b0;
         wen_set <= 1'b0;
         wen_clr <= 1'b0;
         if (!cs_s) begin
            state <= ST_HUNT;
            cnt   <= '0;
         end else if (sk_rise) begin
            unique case (state)
               ST_HUNT: begin
                  if (di_s) begin
                     state <= ST_OPC;
                     cnt   <= '0;
                     armed <= 1'b0;
                  end
               end
               ST_OPC: begin
                  opc <= {opc[0], di_s};
                  if (cnt == CW'(1)) begin
                     state <= ST_ADR;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_ADR: begin
                  addr <= nxt_addr;
                  if (cnt == LAST_A) begin
                     cnt <= '0;
                     case (opc)
                        OP_READ: begin
                           state  <= ST_RD;
                           rd_bit <= 1'b0;
                        end
                        OP_WRITE: state <= ST_WDAT;
                        OP_SPECIAL: begin
                           state <= ST_DONE;
                           if (nxt_addr[ADDR_W-1 -: 2] == SUB_ENABLE)  wen_set <= 1'b1;
                           if (nxt_addr[ADDR_W-1 -: 2] == SUB_DISABLE) wen_clr <= 1'b1;
                        end
                        default: state <= ST_DONE;
                     endcase
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_RD: begin
                  rd_bit <= rd_data[LAST_D - cnt];
                  if (cnt == LAST_D) begin
                     cnt  <= '0;
                     addr <= addr + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_WDAT: begin
                  shreg <= nxt_data;
                  if (cnt == LAST_D) begin
                     state   <= ST_DONE;
                     wr_req  <= 1'b1;
                     wr_data <= nxt_data;
                     armed   <= 1'b1;
                     cnt     <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign rd_active = (state == ST_RD);
   assign do_oe     = cs_s && (rd_active || (state == ST_HUNT && armed));
   assign do_bit    = do_oe && (rd_active ? rd_bit : !busy);
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
   parameter int ADDR_W       = 6,
   parameter int DATA_W       = 16,
   parameter int WRITE_CYCLES = 1000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sk_i,
   input  logic di_i,
   output logic do_o,
   output logic do_oe_o
);
   generate
      if (ADDR_W < 2 || ADDR_W > DATA_W) begin : g_bad_addr
         $error("ADDR_W must be between 2 and DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (WRITE_CYCLES < 1) begin : g_bad_wc
         $error("WRITE_CYCLES must be positive");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be positive");
      end
   endgenerate

   logic [2:0]        sync_q;
   logic              cs_s, sk_s, di_s, sk_d, sk_rise;
   logic              busy, wen, wr_req, wen_set, wen_clr, rd_active;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] rd_data, wr_data;

   sep_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_i, sk_i, di_i}),
      .q     (sync_q)
   );

   assign {cs_s, sk_s, di_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sk_d <= 1'b0;
      else        sk_d <= sk_s;
   end
   assign sk_rise = sk_s && !sk_d;

   sep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .sk_rise   (sk_rise),
      .di_s      (di_s),
      .busy      (busy),
      .rd_data   (rd_data),
      .addr      (addr),
      .wr_req    (wr_req),
      .wr_data   (wr_data),
      .wen_set   (wen_set),
      .wen_clr   (wen_clr),
      .do_bit    (do_o),
      .do_oe     (do_oe_o),
      .rd_active (rd_active)
   );

   sep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_CYCLES(WRITE_CYCLES)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wen_set (wen_set),
      .wen_clr (wen_clr),
      .wr_req  (wr_req),
      .wr_addr (addr),
      .wr_data (wr_data),
      .rd_addr (addr),
      .rd_data (rd_data),
      .busy    (busy),
      .wen     (wen)
   );
endmodule

// File: rtl/sep_checker.sv
module sep_checker #(
   parameter int WRITE_CYCLES = 1000
) (
   input logic clk,
   input logic rst_n,
   input logic cs_s,
   input logic do_o,
   input logic do_oe_o,
   input logic busy,
   input logic wen,
   input logic wr_req,
   input logic rd_active
);
   localparam int TW = $clog2(WRITE_CYCLES + 2);
   logic [TW-1:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= '0;
      else if (busy) busy_len <= busy_len + 1'b1;
      else           busy_len <= '0;
   end

   assert_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!cs_s) && !cs_s) |-> !do_oe_o);

   assert_dummy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_active) |-> (do_oe_o && !do_o));

   assert_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(wen) && $past(wr_req)));

   assert_busy_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == TW'(WRITE_CYCLES)));

   assert_busy_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_len < TW'(WRITE_CYCLES)));

   assert_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (do_oe_o && !rd_active) |-> (do_o == !busy));
endmodule

bind serial_eeprom_slave sep_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_s      (cs_s),
   .do_o      (do_o),
   .do_oe_o   (do_oe_o),
   .busy      (busy),
   .wen       (wen),
   .wr_req    (wr_req),
   .rd_active (rd_active)
);

// File: tb/serial_eeprom_slave_bench.sv
module serial_eeprom_slave_bench;
   localparam int WC = 800;

   logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
   logic do_o, do_oe;

   always #5 clk = ~clk;

   serial_eeprom_slave #(.WRITE_CYCLES(WC)) u_serial_eeprom_slave (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
      .do_o(do_o), .do_oe_o(do_oe)
   );

   typedef struct {
      logic  oe;
      logic  b;
      string tag;
   } exp_t;

   exp_t        q[$];
   event        ev;
   int          n_chk = 0, n_bad = 0;
   logic [15:0] model [64];
   bit          done = 0;

   // monitor: pops expected items and compares against the pins
   initial begin
      forever begin
         @(ev);
         while (q.size() > 0) begin
            exp_t e;
            bit ok;
            e = q.pop_front();
            n_chk++;
            if (e.oe) ok = (do_oe === 1'b1) && (do_o === e.b);
            else      ok = (do_oe === 1'b0);
            if (!ok) begin
               n_bad++;
               $display("FAIL %s: actual oe=%b do=%b expected oe=%b do=%b",
                        e.tag, do_oe, do_o, e.oe, e.b);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_do(input logic oe, input logic b, input string tag);
      exp_t e;
      e.oe = oe; e.b = b; e.tag = tag;
      q.push_back(e);
      -> ev;
      tick(1);
   endtask

   task automatic send_bit(input logic b);
      di = b;
      tick(8);
      sk = 1'b1;
      tick(8);
      sk = 1'b0;
   endtask

   task automatic send_addr(input logic [5:0] a);
      for (int i = 5; i >= 0; i--) send_bit(a[i]);
   endtask

   task automatic cs_up();
      cs = 1'b1;
      tick(8);
   endtask

   task automatic cs_down();
      tick(2);
      cs = 1'b0;
      tick(8);
      expect_do(1'b0, 1'b0, "R1 hiz with select low");
   endtask

   // read n words from a; select may already be high
   task automatic rd_words(input logic [5:0] a, input int n, input int zeros,
                           input bit already_up, input string tag);
      if (!already_up) cs_up();
      for (int z = 0; z < zeros; z++) send_bit(1'b0);
      send_bit(1'b1);
      expect_do(1'b0, 1'b0, "R9 status ends at start bit");
      send_bit(1'b1); send_bit(1'b0);
      send_addr(a);
      expect_do(1'b1, 1'b0, "R5 dummy zero");
      for (int w = 0; w < n; w++) begin
         logic [5:0] aw;
         aw = a + 6'(w);
         for (int i = 15; i >= 0; i--) begin
            send_bit(1'b0);
            expect_do(1'b1, model[aw][i], tag);
         end
      end
      cs_down();
   endtask

   task automatic wr_word(input logic [5:0] a, input logic [15:0] d, input bit acc);
      cs_up();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      send_addr(a);
      for (int i = 15; i >= 0; i--) send_bit(d[i]);
      cs_down();
      if (acc) model[a] = d;
   endtask

   task automatic special(input logic [5:0] a);
      cs_up();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
      send_addr(a);
      cs_down();
   endtask

   task automatic wait_ready();
      cs_up();
      expect_do(1'b1, 1'b0, "R9 busy shown");
      tick(WC + 50);
      expect_do(1'b1, 1'b1, "R9 ready shown");
      cs_down();
   endtask

   initial begin
      for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
      tick(4);
      expect_do(1'b0, 1'b0, "R1 hiz in reset");
      rst_n = 1'b1;
      tick(4);
      expect_do(1'b0, 1'b0, "R1 hiz after reset");

      rd_words(6'd5, 1, 0, 0, "R2 erased after reset");

      // write while disabled: ignored, status reports ready
      wr_word(6'd5, 16'hA5C3, 0);
      cs_up();
      expect_do(1'b1, 1'b1, "R8 disabled write leaves ready");
      cs_down();
      rd_words(6'd5, 1, 0, 0, "R8 disabled write ignored");

      special(6'b110101);                // R4 enable
      wr_word(6'd5, 16'hA5C3, 1);
      cs_up();
      expect_do(1'b1, 1'b0, "R9 busy after write");
      tick(WC + 50);
      expect_do(1'b1, 1'b1, "R9 ready after write time");
      send_bit(1'b0);
      expect_do(1'b1, 1'b1, "R3 zero before start keeps status");
      rd_words(6'd5, 1, 2, 1, "R3 R5 read after leading zeros");

      // second write while first is busy is ignored
      wr_word(6'd6, 16'h5AF0, 1);
      wr_word(6'd7, 16'h1111, 0);
      cs_up();
      expect_do(1'b1, 1'b0, "R8 still busy");
      tick(WC + 50);
      expect_do(1'b1, 1'b1, "R9 ready");
      cs_down();
      rd_words(6'd5, 3, 0, 0, "R6 R8 auto-increment read");

      wr_word(6'd63, 16'h1234, 1);
      wait_ready();
      wr_word(6'd0, 16'h0F0F, 1);
      wait_ready();
      rd_words(6'd63, 2, 0, 0, "R6 wrap 63 to 0");

      wr_word(6'd5, 16'h1234, 1);
      wait_ready();
      rd_words(6'd5, 1, 0, 0, "R7 word fully replaced");

      // R10 abort a partial command, then read
      cs_up();
      send_bit(1'b1); send_bit(1'b1);
      cs_down();
      rd_words(6'd6, 1, 0, 0, "R10 after aborted command");
      // R1 abort a read mid-word
      cs_up();
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      send_addr(6'd6);
      expect_do(1'b1, 1'b0, "R5 dummy zero");
      send_bit(1'b0);
      expect_do(1'b1, model[6][15], "R5 first bit");
      cs_down();

      special(6'b001010);                // R11 disable
      wr_word(6'd9, 16'h0000, 0);
      rd_words(6'd9, 1, 0, 0, "R11 write blocked after disable");
      rd_words(6'd5, 1, 0, 0, "R11 read while disabled");

      tick(4);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule